// File: doc/BRIEF.md
# Hamming SEC Link Codec

This block protects one point-to-point link between two network routers against single-bit upsets. The sending side turns each flit into a Hamming codeword by inserting parity bits at the power-of-two positions. The receiving side computes a syndrome from the arriving word. It flips the one bit the syndrome names, removes the parity bits and hands the repaired flit onward, together with a valid strobe and per-flit status flags. The default flit is 37 bits wide: a 32-bit payload, 4 byte-lane enables and an end-of-packet marker. It travels as a 43-bit link word. A 33-bit flit (payload plus end-of-packet) is obtained by setting the width parameter.

A build-time parameter decides how the receiver is pipelined. In the compact form, syndrome and repair are evaluated together and registered once, so the link gains one cycle. In the split form, the syndrome is registered in a first stage and repair happens in a second, registered stage, giving two cycles. A further option in the split form lets flits with a zero syndrome skip the repair XOR in the second stage. Both forms accept one flit per cycle.

Top module: `hsec_link_codec`

## Requirements
- R1: Link bit `i` carries codeword position `i+1`. Parity bit `k` sits at link bit `2^k-1`, and the flit bits fill the remaining positions in ascending order, flit bit 0 first. Each parity bit makes the XOR over all positions whose index has bit `k` set equal to zero.
- R2: A received word with zero syndrome delivers the original flit with both status flags low.
- R3: A received word with exactly one flipped bit, at any of the codeword positions, delivers the original flit with the corrected flag high and the uncorrectable flag low.
- R4: When the syndrome value exceeds the codeword width, the uncorrectable flag is high, the corrected flag is low, and the flit bits are delivered exactly as received, without any flip.
- R5: The output valid equals the input valid delayed by exactly one cycle in the compact form (`SPLIT=0`) and by exactly two cycles in the split form (`SPLIT=1`). The outputs of each flit appear in the same cycle as its output valid.
- R6: Flits presented on consecutive cycles are all delivered, in order, one per cycle.
- R7: The corrected and uncorrectable flags are never high together, and neither is high in a cycle whose output valid is low. Each flag therefore pulses for one cycle per affected flit.
- R8: The correction bypass option (`BYPASS=1`, split form) gives outputs identical to the model for every input.
- R9: A synchronous active-high reset empties the pipeline. After reset the output valid is low, and flits presented while reset is high are never delivered.
- R10: With `DATA_W=33` the codec uses 6 parity bits on a 39-bit link word and meets R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_data_i | input | DATA_W | Flit to be encoded for transmission |
| enc_word_o | output | CODE_W | Encoded link word (combinational) |
| dec_valid_i | input | 1 | Received link word is valid |
| dec_word_i | input | CODE_W | Received link word |
| dec_valid_o | output | 1 | Delivered flit is valid |
| dec_data_o | output | DATA_W | Delivered (repaired) flit |
| dec_fixed_o | output | 1 | One bit of the delivered flit's codeword was flipped |
| dec_uncorr_o | output | 1 | Syndrome pointed outside the codeword; flit passed unrepaired |

## Verification
The bench builds three copies side by side: a 37-bit compact decoder, a 37-bit split decoder with the bypass enabled, and a 33-bit split decoder without it. On the 43-bit and 39-bit words this makes it cheap to flip every single position under several payloads. It also covers every two-bit error pair whose syndrome lands beyond position 43, so the out-of-range path is reached as well as repair. Running both pipeline depths against the same stimulus exposes any latency or ordering slip, including around a reset asserted mid-stream.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    typedef enum logic [1:0] {
        DEC_CLEAN  = 2'd0,
        DEC_FIXED  = 2'd1,
        DEC_UNCORR = 2'd2
    } dec_kind_t;

    // Smallest parity count p with 2^p >= data_w + p + 1
    function automatic int check_bits(input int data_w);
        int p;
        p = 1;
        while ((1 << p) < data_w + p + 1) p++;
        return p;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Position mask of codeword positions (1-based) whose index has bit k set
    function automatic logic [127:0] cover_mask(input int k, input int n);
        logic [127:0] m;
        m = '0;
        for (int pos = 1; pos <= n; pos++) begin
            if (((pos >> k) & 1) == 1) m[pos-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder
    import hsec_pkg::*;
#(
    parameter  int DATA_W = 37,
    localparam int CHK_W  = check_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] spread;
    logic [CHK_W-1:0]  parity;

    for (genvar pos = 1; pos <= CODE_W; pos++) begin : g_pos
        if (is_pow2(pos)) begin : g_chk
            assign spread[pos-1] = 1'b0;
            assign code_o[pos-1] = parity[$clog2(pos)];
        end else begin : g_dat
            localparam int IDX = pos - $clog2(pos + 1) - 1;
            assign spread[pos-1] = data_i[IDX];
            assign code_o[pos-1] = data_i[IDX];
        end
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_par
        localparam logic [CODE_W-1:0] COVER = CODE_W'(cover_mask(k, CODE_W));
        assign parity[k] = ^(spread & COVER);
    end

endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome
    import hsec_pkg::*;
#(
    parameter  int DATA_W = 37,
    localparam int CHK_W  = check_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syn_o
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        localparam logic [CODE_W-1:0] COVER = CODE_W'(cover_mask(k, CODE_W));
        assign syn_o[k] = ^(code_i & COVER);
    end

endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector
    import hsec_pkg::*;
#(
    parameter  int DATA_W = 37,
    parameter  int BYPASS = 0,
    localparam int CHK_W  = check_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] data_o,
    output dec_kind_t         kind_o
);

    logic [CODE_W-1:0] repaired;
    logic [DATA_W-1:0] raw_data;
    logic [DATA_W-1:0] fix_data;
    logic              syn_zero;
    logic              in_range;

    for (genvar pos = 1; pos <= CODE_W; pos++) begin : g_pos
        localparam logic [CHK_W-1:0] HIT = CHK_W'(pos);
        assign repaired[pos-1] = code_i[pos-1] ^ (syn_i == HIT);
        if (!is_pow2(pos)) begin : g_dat
            localparam int IDX = pos - $clog2(pos + 1) - 1;
            assign raw_data[IDX] = code_i[pos-1];
            assign fix_data[IDX] = repaired[pos-1];
        end
    end

    assign syn_zero = (syn_i == '0);
    assign in_range = !syn_zero && (syn_i <= CHK_W'(CODE_W));

    always_comb begin
        if (syn_zero)      kind_o = DEC_CLEAN;
        else if (in_range) kind_o = DEC_FIXED;
        else               kind_o = DEC_UNCORR;
    end

    if (BYPASS != 0) begin : g_bypass
        assign data_o = syn_zero ? raw_data : fix_data;
    end else begin : g_direct
        assign data_o = fix_data;
    end

endmodule

// File: rtl/hsec_link_codec.sv
module hsec_link_codec
    import hsec_pkg::*;
#(
    parameter  int DATA_W = 37,
    parameter  int SPLIT  = 0,
    parameter  int BYPASS = 0,
    localparam int CHK_W  = check_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_word_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_word_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_fixed_o,
    output logic              dec_uncorr_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        dec_kind_t         kind;
    } dec_out_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
        logic [CHK_W-1:0]  syn;
    } det_stage_t;

    dec_out_t          out_q;
    logic [CHK_W-1:0]  syn_now;
    logic [DATA_W-1:0] cor_data;
    dec_kind_t         cor_kind;

    hsec_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_word_o)
    );

    hsec_syndrome #(.DATA_W(DATA_W)) u_syn (
        .code_i (dec_word_i),
        .syn_o  (syn_now)
    );

    if (SPLIT == 0) begin : g_single
        hsec_corrector #(.DATA_W(DATA_W), .BYPASS(0)) u_cor (
            .code_i (dec_word_i),
            .syn_i  (syn_now),
            .data_o (cor_data),
            .kind_o (cor_kind)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
            end else begin
                out_q.valid <= dec_valid_i;
                out_q.data  <= cor_data;
                out_q.kind  <= cor_kind;
            end
        end
    end else begin : g_split
        det_stage_t det_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                det_q <= '0;
            end else begin
                det_q.valid <= dec_valid_i;
                det_q.code  <= dec_word_i;
                det_q.syn   <= syn_now;
            end
        end

        hsec_corrector #(.DATA_W(DATA_W), .BYPASS(BYPASS)) u_cor (
            .code_i (det_q.code),
            .syn_i  (det_q.syn),
            .data_o (cor_data),
            .kind_o (cor_kind)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
            end else begin
                out_q.valid <= det_q.valid;
                out_q.data  <= cor_data;
                out_q.kind  <= cor_kind;
            end
        end
    end

    assign dec_valid_o  = out_q.valid;
    assign dec_data_o   = out_q.data;
    assign dec_fixed_o  = out_q.valid && (out_q.kind == DEC_FIXED);
    assign dec_uncorr_o = out_q.valid && (out_q.kind == DEC_UNCORR);

endmodule

// File: rtl/hsec_link_codec_chk.sv
module hsec_link_codec_chk
    import hsec_pkg::*;
#(
    parameter  int DATA_W = 37,
    parameter  int SPLIT  = 0,
    localparam int CHK_W  = check_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CODE_W-1:0] enc_word_o,
    input logic              dec_valid_i,
    input logic [CODE_W-1:0] dec_word_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_fixed_o,
    input logic              dec_uncorr_o
);

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_fixed_o && dec_uncorr_o));

    // R7
    flags_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_fixed_o || dec_uncorr_o) |-> dec_valid_o);

    if (SPLIT == 0) begin : g_lat1
        // R5
        valid_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            dec_valid_i |=> dec_valid_o);
        // R5
        idle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            !dec_valid_i |=> !dec_valid_o);
        // R2
        loopback_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_valid_i && (dec_word_i == enc_word_o)) |=>
            ((dec_data_o == $past(enc_data_i)) && !dec_fixed_o && !dec_uncorr_o));
    end else begin : g_lat2
        // R5
        valid_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            dec_valid_i |=> ##1 dec_valid_o);
        // R5
        idle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            !dec_valid_i |=> ##1 !dec_valid_o);
        // R2
        loopback_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_valid_i && (dec_word_i == enc_word_o)) |=> ##1
            ((dec_data_o == $past(enc_data_i, 2)) && !dec_fixed_o && !dec_uncorr_o));
    end

endmodule

bind hsec_link_codec hsec_link_codec_chk #(
    .DATA_W (DATA_W),
    .SPLIT  (SPLIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enc_data_i   (enc_data_i),
    .enc_word_o   (enc_word_o),
    .dec_valid_i  (dec_valid_i),
    .dec_word_i   (dec_word_i),
    .dec_valid_o  (dec_valid_o),
    .dec_data_o   (dec_data_o),
    .dec_fixed_o  (dec_fixed_o),
    .dec_uncorr_o (dec_uncorr_o)
);

// File: tb/hsec_link_codec_bench.sv
`timescale 1ns/1ps
module hsec_link_codec_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v   = 1'b0;
    logic [36:0] d37 = '0;
    logic [32:0] d33 = '0;
    logic [42:0] w37 = '0;
    logic [38:0] w33 = '0;

    logic [42:0] e0, e1;
    logic [38:0] e2;
    logic        ov0, ov1, ov2, of0, of1, of2, ou0, ou1, ou2;
    logic [36:0] od0, od1;
    logic [32:0] od2;

    int n_cmp = 0;
    int n_bad = 0;
    int k     = 0;
    bit done  = 0;

    logic        hv [0:2][0:4095];
    logic        hf [0:2][0:4095];
    logic        hu [0:2][0:4095];
    logic [63:0] hd [0:2][0:4095];
    string       ht [0:4095];
    string       dn [0:2] = '{"w37_single", "w37_split_R8", "w33_R10"};

    always #4 clk = ~clk;

    hsec_link_codec #(.DATA_W(37), .SPLIT(0), .BYPASS(0)) u_hsec_link_codec (
        .clk(clk), .rst(rst), .enc_data_i(d37), .enc_word_o(e0),
        .dec_valid_i(v), .dec_word_i(w37), .dec_valid_o(ov0),
        .dec_data_o(od0), .dec_fixed_o(of0), .dec_uncorr_o(ou0));

    hsec_link_codec #(.DATA_W(37), .SPLIT(1), .BYPASS(1)) u_split (
        .clk(clk), .rst(rst), .enc_data_i(d37), .enc_word_o(e1),
        .dec_valid_i(v), .dec_word_i(w37), .dec_valid_o(ov1),
        .dec_data_o(od1), .dec_fixed_o(of1), .dec_uncorr_o(ou1));

    hsec_link_codec #(.DATA_W(33), .SPLIT(1), .BYPASS(0)) u_narrow (
        .clk(clk), .rst(rst), .enc_data_i(d33), .enc_word_o(e2),
        .dec_valid_i(v), .dec_word_i(w33), .dec_valid_o(ov2),
        .dec_data_o(od2), .dec_fixed_o(of2), .dec_uncorr_o(ou2));

    function automatic int nchk(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic bit pow2(input int x);
        return (x & (x - 1)) == 0;
    endfunction

    // R1 model: data in non-power-of-two positions, parity at 2^k
    function automatic logic [63:0] m_enc(input logic [63:0] d, input int dw);
        logic [63:0] cw;
        int n, idx, s;
        n = dw + nchk(dw);
        cw = '0;
        idx = 0;
        for (int pos = 1; pos <= n; pos++) begin
            if (!pow2(pos)) begin
                cw[pos-1] = d[idx];
                idx++;
            end
        end
        s = 0;
        for (int pos = 1; pos <= n; pos++) if (cw[pos-1]) s = s ^ pos;
        for (int b = 0; b < nchk(dw); b++) cw[(1 << b) - 1] = s[b];
        return cw;
    endfunction

    function automatic logic [63:0] m_ext(input logic [63:0] cw, input int dw);
        logic [63:0] d;
        int idx;
        d = '0;
        idx = 0;
        for (int pos = 1; pos <= dw + nchk(dw); pos++) begin
            if (!pow2(pos)) begin
                d[idx] = cw[pos-1];
                idx++;
            end
        end
        return d;
    endfunction

    task automatic m_dec(input logic [63:0] w, input int dw,
                         output logic [63:0] dd, output logic f, output logic u);
        int s, n;
        logic [63:0] one;
        one = 64'd1;
        n = dw + nchk(dw);
        s = 0;
        for (int pos = 1; pos <= n; pos++) if (w[pos-1]) s = s ^ pos;
        f = 1'b0;
        u = 1'b0;
        if (s == 0) begin
            dd = m_ext(w, dw);
        end else if (s <= n) begin
            f = 1'b1;
            dd = m_ext(w ^ (one << (s - 1)), dw);
        end else begin
            u = 1'b1;
            dd = m_ext(w, dw);
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic vv, input logic [63:0] data,
                        input logic [63:0] m37, input logic [63:0] m33, input string tag);
        logic [63:0] c37, c33, dd;
        logic f, u;
        int s;
        for (int j = 0; j < 3; j++) begin
            int lat = (j == 0) ? 1 : 2;
            int idx = k - lat;
            logic ev = 1'b0;
            logic ef = 1'b0;
            logic eu = 1'b0;
            logic [63:0] ed = '0;
            string et = "R5";
            logic av, af, au;
            logic [63:0] ad;
            if (idx >= 0) begin
                ev = hv[j][idx % 4096];
                ef = hf[j][idx % 4096];
                eu = hu[j][idx % 4096];
                ed = hd[j][idx % 4096];
                et = ht[idx % 4096];
            end
            case (j)
                0: begin av = ov0; af = of0; au = ou0; ad = 64'(od0); end
                1: begin av = ov1; af = of1; au = ou1; ad = 64'(od1); end
                default: begin av = ov2; af = of2; au = ou2; ad = 64'(od2); end
            endcase
            chk({"R5/R9 ", dn[j]}, 64'(av), 64'(ev), "valid");
            if (ev) begin
                chk({et, "/R6 ", dn[j]}, ad, ed, "data");
                chk({et, " ", dn[j]}, 64'(af), 64'(ef), "fixed");
                chk({et, " ", dn[j]}, 64'(au), 64'(eu), "uncorr");
            end else begin
                chk({"R7 ", dn[j]}, 64'(af), 64'd0, "fixed idle");
                chk({"R7 ", dn[j]}, 64'(au), 64'd0, "uncorr idle");
            end
        end

        c37 = m_enc(data & 64'h1F_FFFF_FFFF, 37) ^ m37;
        c33 = m_enc(data & 64'h1_FFFF_FFFF, 33) ^ m33;
        rst = r;
        v   = vv;
        d37 = data[36:0];
        d33 = data[32:0];
        w37 = c37[42:0];
        w33 = c33[38:0];
        s = k % 4096;
        ht[s] = tag;
        m_dec(c37, 37, dd, f, u);
        for (int j = 0; j < 2; j++) begin
            hv[j][s] = vv && !r;
            hd[j][s] = dd;
            hf[j][s] = f;
            hu[j][s] = u;
        end
        m_dec(c33, 33, dd, f, u);
        hv[2][s] = vv && !r;
        hd[2][s] = dd;
        hf[2][s] = f;
        hu[2][s] = u;
        if (r) begin
            for (int b = 1; b <= 2; b++) begin
                if (k - b >= 0) for (int j = 0; j < 3; j++) hv[j][(k - b) % 4096] = 1'b0;
            end
        end
        #1;
        c37 = m_enc(data & 64'h1F_FFFF_FFFF, 37);
        c33 = m_enc(data & 64'h1_FFFF_FFFF, 33);
        chk("R1 w37", 64'(e0), c37, "encode");
        chk("R1 w37_split", 64'(e1), c37, "encode");
        chk("R10 w33", 64'(e2), c33, "encode");
        k++;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] one;
        logic [63:0] pat [0:3];
        one = 64'd1;
        for (int j = 0; j < 3; j++)
            for (int i = 0; i < 4096; i++) hv[j][i] = 1'b0;
        @(negedge clk);

        // R9: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, '0, '0, "R9");

        // R2: clean flits, walking ones then random, back to back (R6)
        for (int i = 0; i < 37; i++) step(1'b0, 1'b1, one << i, '0, '0, "R2");
        for (int i = 0; i < 40; i++)
            step(1'b0, 1'b1, {$urandom(), $urandom()}, '0, '0, "R2");

        // R3: every single-bit error position
        pat[0] = '0;
        pat[1] = '1;
        pat[2] = {$urandom(), $urandom()};
        pat[3] = 64'hA5A5_5A5A_C3C3_3C3C;
        for (int t = 0; t < 4; t++)
            for (int p = 1; p <= 43; p++)
                step(1'b0, 1'b1, pat[t], one << (p - 1), one << ((p - 1) % 39), "R3");

        // R4: two-bit errors whose syndrome exceeds the 43-position word
        for (int p = 1; p <= 43; p++)
            for (int q = p + 1; q <= 43; q++)
                if ((p ^ q) > 43)
                    step(1'b0, 1'b1, {$urandom(), $urandom()},
                         (one << (p - 1)) | (one << (q - 1)),
                         (one << ((p - 1) % 39)) ^ (one << ((q - 1) % 39)), "R4");

        // R5: gaps in valid
        for (int i = 0; i < 24; i++)
            step(1'b0, (i % 3) != 1, {$urandom(), $urandom()},
                 (i % 2 == 0) ? (one << (i % 39)) : '0, '0, "R5");

        // R9: reset mid-stream with valid flits offered during reset
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, {$urandom(), $urandom()}, '0, '0, "R9");
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, {$urandom(), $urandom()}, '0, '0, "R9");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, {$urandom(), $urandom()}, '0, '0, "R9");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, {$urandom(), $urandom()}, one, '0, "R3");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, '0, '0, "R5");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule